// File: doc/BRIEF.md
# Wake-on-LAN Power State Controller

This block tracks whether a network controller is armed to wake the host over the LAN. Once it is armed, it watches the per-frame receive results for a magic-packet match. A match raises a sticky PCI power-management request and, in a low-power state, a status-change pulse with a fixed length of 52 ms. The pulse length is counted from a 1 ms tick supplied from outside. Packet parsing, the PCI configuration space and the EEPROM reader sit outside the block. They reach it only as strobes and flags.

The block is armed after two things have happened. The alternate reset has finished, and the EEPROM load has completed with the wake-enable bit set. Programming a memory or I/O base address register takes the block out of wake mode, and the device returns to the fully active state. While the block is armed, it flags flash access as not permitted. Configuration access remains available, so nothing in this block gates it. The activity LED also changes meaning while armed. It then shows only frames that passed individual-address or broadcast filtering, not general link activity.

Top module: `wol_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no other stimulus, `pme_o`, `stschg_o`, `flash_block_o` and `led_o` are all low.
- R2: If `ee_done_i` pulses while `rst_done_i` and `ee_wake_en_i` are both high, wake mode starts and `flash_block_o` rises on the next cycle. If either level is low during that pulse, the block does not arm.
- R3: `bar_set_i` ends wake mode, and `flash_block_o` is low on the next cycle. It wins over an arming condition in the same cycle.
- R4: In wake mode, a frame with `frm_vld_i` and `frm_magic_i` both high sets `pme_o` on the next cycle. `pme_o` then stays high, even after wake mode ends, until it is cleared.
- R5: `pme_clr_i` (write-one-to-clear) drops `pme_o` on the next cycle. It wins over a magic frame in the same cycle.
- R6: A magic frame outside wake mode changes neither `pme_o` nor `stschg_o`.
- R7: A magic frame in wake mode raises `stschg_o` on the next cycle only if `pwr_state_i` is 1, 2, 3 or 4 (D0u, D1, D2, D3). With code 0 (D0a), or with the unused codes 5 to 7, there is no pulse.
- R8: `stschg_o` stays high through exactly 52 `ms_tick_i` cycles counted after the start. It falls on the cycle after the 52nd tick.
- R9: A valid frame with `frm_other_i` high and `frm_magic_i` low clears `stschg_o` on the next cycle.
- R10: A further qualifying magic frame while the pulse is running restarts the full 52-tick count.
- R11: In wake mode, `led_o` is high exactly on the cycle after a valid frame with `frm_ia_ok_i` or `frm_bc_ok_i` set. Outside wake mode, `led_o` follows `act_i` one cycle late.
- R12: In wake mode, `act_i` has no effect on `led_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_done_i | input | 1 | Alternate reset has completed (level) |
| ee_done_i | input | 1 | EEPROM load finished (one-cycle strobe) |
| ee_wake_en_i | input | 1 | Wake-enable bit from EEPROM |
| pwr_state_i | input | 3 | Power state: 0 D0a, 1 D0u, 2 D1, 3 D2, 4 D3 |
| bar_set_i | input | 1 | Memory or I/O base address programmed (strobe) |
| frm_vld_i | input | 1 | Receive result strobe for one frame |
| frm_magic_i | input | 1 | Frame was a magic packet |
| frm_other_i | input | 1 | Frame was a message unrelated to wake |
| frm_ia_ok_i | input | 1 | Frame passed individual-address filter |
| frm_bc_ok_i | input | 1 | Frame passed broadcast filter |
| act_i | input | 1 | General link activity |
| ms_tick_i | input | 1 | One-cycle strobe every millisecond |
| pme_clr_i | input | 1 | Write-one-to-clear for the PME request |
| pme_o | output | 1 | Sticky power-management event request |
| stschg_o | output | 1 | Timed status-change pulse |
| flash_block_o | output | 1 | Flash access not permitted (wake mode) |
| led_o | output | 1 | Activity LED drive |

## Verification
A wrong arm flag shows up at `flash_block_o` one cycle after the strobe that should have changed it. It also affects `pme_o` and `stschg_o` one cycle after the next magic frame. A corrupted pulse counter may show nothing until the pulse should end. It then appears as a pulse that falls one or more ticks early or late, or as one that never falls. So the 52-tick boundary and the restart case have to be checked tick by tick. A wrong LED mux select shows up on the cycle after any frame or activity change.

// File: rtl/wol_pkg.sv
package wol_pkg;

  typedef enum logic [2:0] {
    PWR_D0A = 3'd0,
    PWR_D0U = 3'd1,
    PWR_D1  = 3'd2,
    PWR_D2  = 3'd3,
    PWR_D3  = 3'd4
  } pwr_state_e;

  function automatic logic pwr_is_low(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

endpackage

// File: rtl/wol_rst_sync.sv
module wol_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/wol_arm_ctrl.sv
module wol_arm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_done_i,
  input  logic ee_done_i,
  input  logic ee_wake_en_i,
  input  logic bar_set_i,
  output logic armed_o
);

  logic arm_req;
  logic armed_d, armed_q, armed_en;

  always_comb begin
    arm_req  = ee_done_i & rst_done_i & ee_wake_en_i;
    armed_en = arm_req | bar_set_i;
    armed_d  = armed_q;
    if (bar_set_i)    armed_d = 1'b0;
    else if (arm_req) armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed_o = armed_q;

  assert_bar_exits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bar_set_i |=> !armed_q);

  assert_arm_needs_cond_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q ##1 armed_q |-> $past(ee_done_i & rst_done_i & ee_wake_en_i));

endmodule

// File: rtl/wol_pme_req.sv
module wol_pme_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic magic_hit_i,
  input  logic pme_clr_i,
  output logic pme_o
);

  logic pme_set;
  logic pme_d, pme_q, pme_en;

  always_comb begin
    pme_set = armed_i & magic_hit_i;
    pme_en  = pme_set | pme_clr_i;
    pme_d   = pme_q;
    if (pme_clr_i)    pme_d = 1'b0;
    else if (pme_set) pme_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pme_q <= 1'b0;
    else if (pme_en) pme_q <= pme_d;
  end

  assign pme_o = pme_q;

  assert_clr_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pme_clr_i |=> !pme_q);

  assert_magic_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && magic_hit_i && !pme_clr_i) |=> pme_q);

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pme_q && !pme_clr_i) |=> pme_q);

  assert_no_set_unarmed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pme_q && !armed_i) |=> !pme_q);

endmodule

// File: rtl/wol_stschg_timer.sv
module wol_stschg_timer #(
  parameter int PULSE_MS = 52,
  localparam int CNT_W = $clog2(PULSE_MS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       armed_i,
  input  logic [2:0] pwr_state_i,
  input  logic       magic_hit_i,
  input  logic       other_hit_i,
  input  logic       ms_tick_i,
  output logic       pulse_o
);

  import wol_pkg::*;

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_MS);

  logic             start, kill, busy, step;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    busy   = (cnt_q != '0);
    start  = armed_i & magic_hit_i & pwr_is_low(pwr_state_i);
    kill   = other_hit_i;
    step   = ms_tick_i & busy;
    cnt_en = start | kill | step;
    cnt_d  = cnt_q;
    if (start)     cnt_d = LOAD_VAL;
    else if (kill) cnt_d = '0;
    else if (step) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_o = busy;

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);

  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_q == LOAD_VAL));

  assert_kill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill && !start) |=> !pulse_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start && !kill && !ms_tick_i) |=> $stable(cnt_q));

  assert_d0a_none_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !(armed_i && magic_hit_i && pwr_is_low(pwr_state_i))) |=> !pulse_o);

endmodule

// File: rtl/wol_ctrl.sv
module wol_ctrl #(
  parameter int PULSE_MS   = 52,
  parameter int RST_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_done_i,
  input  logic       ee_done_i,
  input  logic       ee_wake_en_i,
  input  logic [2:0] pwr_state_i,
  input  logic       bar_set_i,
  input  logic       frm_vld_i,
  input  logic       frm_magic_i,
  input  logic       frm_other_i,
  input  logic       frm_ia_ok_i,
  input  logic       frm_bc_ok_i,
  input  logic       act_i,
  input  logic       ms_tick_i,
  input  logic       pme_clr_i,
  output logic       pme_o,
  output logic       stschg_o,
  output logic       flash_block_o,
  output logic       led_o
);

  logic rst_n;
  logic armed;
  logic magic_hit, other_hit, filt_hit;
  logic led_d, led_q;

  wol_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  assign magic_hit = frm_vld_i & frm_magic_i;
  assign other_hit = frm_vld_i & frm_other_i & ~frm_magic_i;
  assign filt_hit  = frm_vld_i & (frm_ia_ok_i | frm_bc_ok_i);

  wol_arm_ctrl u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .rst_done_i  (rst_done_i),
    .ee_done_i   (ee_done_i),
    .ee_wake_en_i(ee_wake_en_i),
    .bar_set_i   (bar_set_i),
    .armed_o     (armed)
  );

  wol_pme_req u_pme (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .armed_i    (armed),
    .magic_hit_i(magic_hit),
    .pme_clr_i  (pme_clr_i),
    .pme_o      (pme_o)
  );

  wol_stschg_timer #(.PULSE_MS(PULSE_MS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .armed_i    (armed),
    .pwr_state_i(pwr_state_i),
    .magic_hit_i(magic_hit),
    .other_hit_i(other_hit),
    .ms_tick_i  (ms_tick_i),
    .pulse_o    (stschg_o)
  );

  always_comb begin
    if (armed) led_d = filt_hit;
    else       led_d = act_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= led_d;
  end

  assign led_o         = led_q;
  assign flash_block_o = armed;

  assert_led_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flash_block_o && !frm_vld_i) |=> !led_o);

  assert_led_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!flash_block_o && act_i) |=> led_o);

endmodule

// File: tb/wol_ctrl_tb.sv
module wol_ctrl_tb;

  localparam int PULSE_MS = 52;

  logic clk = 1'b0;
  logic rst_n;
  logic rst_done, ee_done, ee_wake_en, bar_set;
  logic [2:0] pwr;
  logic frm_vld, frm_magic, frm_other, frm_ia, frm_bc;
  logic act, tick, pme_clr;
  logic pme, stschg, fblk, led;

  int checks = 0;
  int fails  = 0;

  // bench reference state
  logic m_armed, m_pme, m_led;
  int   m_cnt;

  always #2 clk = ~clk;

  wol_ctrl #(.PULSE_MS(PULSE_MS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_done_i(rst_done), .ee_done_i(ee_done),
    .ee_wake_en_i(ee_wake_en), .pwr_state_i(pwr), .bar_set_i(bar_set),
    .frm_vld_i(frm_vld), .frm_magic_i(frm_magic), .frm_other_i(frm_other),
    .frm_ia_ok_i(frm_ia), .frm_bc_ok_i(frm_bc), .act_i(act), .ms_tick_i(tick),
    .pme_clr_i(pme_clr), .pme_o(pme), .stschg_o(stschg),
    .flash_block_o(fblk), .led_o(led)
  );

  function automatic logic f_low(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

  function automatic logic f_arm_next(input logic a, input logic b, input logic d,
                                      input logic r, input logic w);
    if (b) return 1'b0;
    if (d && r && w) return 1'b1;
    return a;
  endfunction

  function automatic int f_cnt_next(input int c, input logic start, input logic kill,
                                    input logic tk);
    if (start) return PULSE_MS;
    if (kill) return 0;
    if (tk && c > 0) return c - 1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed <= 1'b0; m_pme <= 1'b0; m_led <= 1'b0; m_cnt <= 0;
    end else begin
      m_armed <= f_arm_next(m_armed, bar_set, ee_done, rst_done, ee_wake_en);
      m_pme   <= pme_clr ? 1'b0 : ((m_armed && frm_vld && frm_magic) ? 1'b1 : m_pme);
      m_cnt   <= f_cnt_next(m_cnt, m_armed && frm_vld && frm_magic && f_low(pwr),
                            frm_vld && frm_other && !frm_magic, tick);
      m_led   <= m_armed ? (frm_vld && (frm_ia || frm_bc)) : act;
    end
  end

  task automatic check(input string req, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act_v, exp_v);
    end
  endtask

  task automatic check_model();
    check("R2/R3 flash_block", fblk, m_armed);
    check("R4/R5 pme", pme, m_pme);
    check("R8 stschg", stschg, m_cnt != 0);
    check("R11 led", led, m_led);
  endtask

  task automatic idle();
    ee_done = 0; bar_set = 0; frm_vld = 0; frm_magic = 0; frm_other = 0;
    frm_ia = 0; frm_bc = 0; act = 0; tick = 0; pme_clr = 0;
  endtask

  // apply current inputs for one edge, then return at the following negedge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic arm();
    rst_done = 1; ee_wake_en = 1; ee_done = 1;
    cyc();
  endtask

  task automatic magic(input logic [2:0] ps);
    pwr = ps; frm_vld = 1; frm_magic = 1;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rst_done = 0; ee_wake_en = 0; pwr = 3'd0; idle();
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check("R1 pme", pme, 0); check("R1 stschg", stschg, 0);
    check("R1 flash", fblk, 0); check("R1 led", led, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 flash after release", fblk, 0);

    // R2: no arm without wake enable, none without reset completion
    rst_done = 1; ee_wake_en = 0; ee_done = 1; cyc();
    check("R2 no arm wake_en=0", fblk, 0);
    rst_done = 0; ee_wake_en = 1; ee_done = 1; cyc();
    check("R2 no arm rst_done=0", fblk, 0);

    // R6: magic while unarmed
    magic(3'd4);
    check("R6 pme unarmed", pme, 0); check("R6 stschg unarmed", stschg, 0);

    // R11: follows act_i when unarmed
    act = 1; cyc(); check("R11 led follows act", led, 1);

    arm();
    check("R2 armed", fblk, 1);

    // R12: act ignored in wake mode
    act = 1; cyc(); check("R12 act ignored", led, 0);
    frm_vld = 1; frm_bc = 1; cyc(); check("R11 bc pass led", led, 1);
    cyc(); check("R11 led drops", led, 0);

    // R7: D0a gives PME but no pulse
    magic(3'd0);
    check("R4 pme set", pme, 1); check("R7 no pulse D0a", stschg, 0);
    pme_clr = 1; cyc(); check("R5 clear", pme, 0);

    // R5: clear wins over magic
    pme_clr = 1; pwr = 3'd2; frm_vld = 1; frm_magic = 1; cyc();
    check("R5 clear priority", pme, 0); check("R7 pulse D1", stschg, 1);

    // R8: exactly 52 ticks
    magic(3'd4);
    for (int i = 1; i < PULSE_MS; i++) begin
      tick = 1; cyc();
    end
    check("R8 high after 51 ticks", stschg, 1);
    cyc(); check("R8 tick hold", stschg, 1);
    tick = 1; cyc(); check("R8 low after 52nd tick", stschg, 0);

    // R10: restart during pulse
    magic(3'd1);
    for (int i = 0; i < 30; i++) begin tick = 1; cyc(); end
    magic(3'd3);
    for (int i = 1; i < PULSE_MS; i++) begin tick = 1; cyc(); end
    check("R10 restarted still high", stschg, 1);
    tick = 1; cyc(); check("R10 restarted ends", stschg, 0);

    // R7: unused code 5
    magic(3'd5); check("R7 no pulse code5", stschg, 0);

    // R9: other message cuts pulse
    magic(3'd2); check("R9 pulse on", stschg, 1);
    frm_vld = 1; frm_other = 1; cyc(); check("R9 cut short", stschg, 0);

    // R3: BAR wins over arm in same cycle
    bar_set = 1; rst_done = 1; ee_wake_en = 1; ee_done = 1; cyc();
    check("R3 bar priority", fblk, 0);
    check("R4 pme sticky after exit", pme, 1);
    magic(3'd4); check("R6 no pulse after exit", stschg, 0);
    pme_clr = 1; cyc();

    // random phase against reference
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 4000; n++) begin
      rst_done   = ($urandom % 8) != 0;
      ee_wake_en = ($urandom % 4) != 0;
      ee_done    = ($urandom % 40) == 0;
      bar_set    = ($urandom % 60) == 0;
      pwr        = 3'($urandom % 6);
      frm_vld    = ($urandom % 3) == 0;
      frm_magic  = ($urandom % 6) == 0;
      frm_other  = ($urandom % 10) == 0;
      frm_ia     = $urandom % 2;
      frm_bc     = ($urandom % 4) == 0;
      act        = $urandom % 2;
      tick       = $urandom % 2;
      pme_clr    = ($urandom % 30) == 0;
      @(posedge clk);
      @(negedge clk);
      check_model();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule